// File: doc/BRIEF.md
# Byte-Serial SPI Master with Dual-Bit Transmit

This block turns single bytes, handed over through a valid/ready request port, into SPI mode 0 traffic. Each request carries the byte, a flag saying whether transmit data is present (zeros go out when it is not), a per-byte choice between one and two transmit bits per serial clock, the chip select to use, and two framing flags: "change select after this byte" and "last byte of message". For every byte sent, the block returns the byte it captured on its serial input through a one-cycle response strobe.

The serial clock is derived from the system clock by a divider programmed on `div_cfg`. Software normally loads it with (f_sys - 1) / (2 * f_max), using integer division. The serial clock then runs at f_sys / (2 * (div + 1)). A setting of 0 is raised to 1 because, at that setting, the first sampled bit cannot be trusted. Three chip selects are provided. Each one is active low unless its bit in `cs_pol` makes it active high.

Top module: `spi_dual_master`

## Requirements
- R1: After reset, `sck`, `mosi`, `mosi2`, `busy` and `rsp_valid` are 0, `req_ready` is 1, and every chip select sits at its inactive level.
- R2: Each low phase and each high phase of `sck` lasts D+1 system clocks. D is the `div_cfg` value sampled when the request is accepted, except that a value of 0 is used as 1. After acceptance `sck` stays low for D+1 clocks before its first rise.
- R3: In single mode (`req_dual`=0) a byte takes 8 `sck` cycles. `mosi` carries bit 7 first and bit 0 last, and `mosi2` stays 0.
- R4: In dual mode (`req_dual`=1) a byte takes 4 `sck` cycles. On cycle k (k = 0 to 3), `mosi` carries bit 7-2k and `mosi2` carries bit 6-2k.
- R5: Transmit lines change only while `sck` is low and stay steady for the whole high phase. `sck` rests low whenever no byte is moving. Outside a transfer, `mosi` and `mosi2` are 0.
- R6: When `req_has_data` is 0, the byte sent is all zeros, whatever is on `req_data`.
- R7: `miso` is sampled at each rising `sck` and shifted in MSB first. After the last falling edge, `rsp_valid` pulses for exactly one cycle, in the same cycle `sck` falls, with `rsp_data` holding the captured byte. In dual mode the 4 sampled bits form the low nibble and the upper nibble is 0.
- R8: `req_cs_sel` values 0 to 2 assert exactly that select for the byte, and all others stay inactive. A `cs_pol` bit of 1 makes its select active high, and 0 makes it active low. A `req_cs_sel` of 3 asserts none. The selects never change while `sck` is high.
- R9: A byte flagged to change select that is not the last of its message releases every select when it ends. The block then stays busy with `req_ready` low for GAP_CYC cycles (default 4), counting the response cycle, before it accepts again.
- R10: A byte flagged to change select that is also the last keeps its select asserted afterwards, awaiting a continuation. A byte with neither flag also keeps its select asserted. A last byte without the change flag ends the message and releases every select, and the block is ready again in the response cycle.
- R11: `req_ready` is high and `busy` low only when no byte is in flight and no gap is running. A request is taken in a cycle where `req_valid` and `req_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_cfg | input | DIV_W | Serial clock divider setting |
| cs_pol | input | NUM_CS | Per-select polarity, 1 = active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_data | input | DATA_W | Byte to transmit |
| req_has_data | input | 1 | 0 = send zeros instead of `req_data` |
| req_dual | input | 1 | 1 = two transmit bits per serial clock |
| req_cs_sel | input | SEL_W | Chip select index |
| req_cs_change | input | 1 | Change select after this byte |
| req_last | input | 1 | Byte ends the message |
| rsp_valid | output | 1 | One-cycle strobe, received byte ready |
| rsp_data | output | DATA_W | Received byte |
| busy | output | 1 | Byte in flight or gap running |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Primary serial data out |
| mosi2 | output | 1 | Secondary data out in dual mode |
| miso | input | 1 | Serial data in |
| cs_o | output | NUM_CS | Chip selects |

## Verification
With half period H = D+1, a request taken at edge E0 drives `sck` low from E0 and raises it at E0+H. The clock then toggles every H edges. For a byte of n serial cycles, the response strobe appears at E0+2nH, and a gap releases `req_ready` GAP_CYC edges later. The bench walks through exactly these cycles in its own model. It samples one time unit after each rising edge and compares every output in every cycle, so a transition that comes early or late by a single clock is reported. Stimulus on `miso` is changed one unit after the edge where `sck` falls, which keeps each bit steady across the rising edge that samples it.

// File: rtl/spi_dm_pkg.sv
package spi_dm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOW  = 2'd1,
      ST_HIGH = 2'd2,
      ST_GAP  = 2'd3
   } dm_state_e;
endpackage

// File: rtl/spi_dm_phase.sv
module spi_dm_phase #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] lim,
   output logic             phase_end
);
   logic [DIV_W-1:0] cnt;

   assign phase_end = run && (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (!run || phase_end) cnt <= '0;
      else                        cnt <= cnt + 1'b1;
   end

   // R2
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= lim));
   // R2
   lim_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (lim != '0));
endmodule

// File: rtl/spi_dm_shift.sv
module spi_dm_shift #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] tx_in,
   input  logic              shift_en,
   input  logic              dual,
   input  logic              sample_en,
   input  logic              miso,
   output logic              tx_hi,
   output logic              tx_lo,
   output logic [DATA_W-1:0] rx
);
   logic [DATA_W-1:0] sh;

   assign tx_hi = sh[DATA_W-1];
   assign tx_lo = sh[DATA_W-2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh <= '0;
         rx <= '0;
      end else begin
         if (load)          sh <= tx_in;
         else if (shift_en) sh <= dual ? {sh[DATA_W-3:0], 2'b00} : {sh[DATA_W-2:0], 1'b0};
         if (load)           rx <= '0;
         else if (sample_en) rx <= {rx[DATA_W-2:0], miso};
      end
   end

   // R7
   no_load_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && (shift_en || sample_en)));
endmodule

// File: rtl/spi_dm_cs.sv
module spi_dm_cs #(
   parameter int NUM_CS = 3,
   parameter int SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [SEL_W-1:0]  sel,
   input  logic              release_all,
   input  logic              in_gap,
   input  logic [NUM_CS-1:0] pol,
   output logic [NUM_CS-1:0] cs_o
);
   logic [NUM_CS-1:0] act, act_nxt;

   for (genvar i = 0; i < NUM_CS; i++) begin : g_sel
      assign act_nxt[i] = (sel == SEL_W'(i));
      assign cs_o[i]    = act[i] ? pol[i] : ~pol[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           act <= '0;
      else if (load)        act <= act_nxt;
      else if (release_all) act <= '0;
   end

   // R8
   cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(act));
   // R9
   gap_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_gap |-> (act == '0));
endmodule

// File: rtl/spi_dual_master.sv
module spi_dual_master
   import spi_dm_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int NUM_CS  = 3,
   parameter int DIV_W   = 8,
   parameter int GAP_CYC = 4,
   parameter int SEL_W   = (NUM_CS > 1) ? $clog2(NUM_CS + 1) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  div_cfg,
   input  logic [NUM_CS-1:0] cs_pol,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [DATA_W-1:0] req_data,
   input  logic              req_has_data,
   input  logic              req_dual,
   input  logic [SEL_W-1:0]  req_cs_sel,
   input  logic              req_cs_change,
   input  logic              req_last,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              busy,
   output logic              sck,
   output logic              mosi,
   output logic              mosi2,
   input  logic              miso,
   output logic [NUM_CS-1:0] cs_o
);
   localparam int BC_W = $clog2(DATA_W);
   localparam int GC_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
   localparam logic [BC_W-1:0] LAST_SINGLE = BC_W'(DATA_W - 1);
   localparam logic [BC_W-1:0] LAST_DUAL   = BC_W'(DATA_W / 2 - 1);

   if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_w
      $error("DATA_W must be even and at least 4");
   end
   if (GAP_CYC < 1) begin : g_bad_gap
      $error("GAP_CYC must be at least 1");
   end
   if (DIV_W < 2) begin : g_bad_div
      $error("DIV_W must be at least 2");
   end

   dm_state_e        state;
   logic [DIV_W-1:0] half_lim;
   logic             dual_q, chg_q, last_q;
   logic [BC_W-1:0]  bitcnt;
   logic [GC_W-1:0]  gcnt;
   logic             phase_end, active, accept, last_bit, done;
   logic             tx_hi, tx_lo;

   assign active    = (state == ST_LOW) || (state == ST_HIGH);
   assign accept    = req_valid && (state == ST_IDLE);
   assign last_bit  = bitcnt == (dual_q ? LAST_DUAL : LAST_SINGLE);
   assign done      = (state == ST_HIGH) && phase_end && last_bit;
   assign req_ready = (state == ST_IDLE);
   assign busy      = (state != ST_IDLE);
   assign mosi      = active && tx_hi;
   assign mosi2     = active && dual_q && tx_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         half_lim  <= DIV_W'(1);
         dual_q    <= 1'b0;
         chg_q     <= 1'b0;
         last_q    <= 1'b0;
         bitcnt    <= '0;
         gcnt      <= '0;
         sck       <= 1'b0;
         rsp_valid <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state)
            ST_IDLE: if (req_valid) begin
               half_lim <= (div_cfg == '0) ? DIV_W'(1) : div_cfg;
               dual_q   <= req_dual;
               chg_q    <= req_cs_change;
               last_q   <= req_last;
               bitcnt   <= '0;
               state    <= ST_LOW;
            end
            ST_LOW: if (phase_end) begin
               sck   <= 1'b1;
               state <= ST_HIGH;
            end
            ST_HIGH: if (phase_end) begin
               sck <= 1'b0;
               if (last_bit) begin
                  rsp_valid <= 1'b1;
                  gcnt      <= '0;
                  state     <= (chg_q && !last_q) ? ST_GAP : ST_IDLE;
               end else begin
                  bitcnt <= bitcnt + 1'b1;
                  state  <= ST_LOW;
               end
            end
            ST_GAP: begin
               if (gcnt == GC_W'(GAP_CYC - 1)) state <= ST_IDLE;
               else                            gcnt  <= gcnt + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   spi_dm_phase #(.DIV_W(DIV_W)) phase_i (
      .clk(clk), .rst_n(rst_n), .run(active), .lim(half_lim), .phase_end(phase_end)
   );

   spi_dm_shift #(.DATA_W(DATA_W)) shift_i (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .tx_in(req_has_data ? req_data : '0),
      .shift_en((state == ST_HIGH) && phase_end && !last_bit),
      .dual(dual_q),
      .sample_en((state == ST_LOW) && phase_end),
      .miso(miso), .tx_hi(tx_hi), .tx_lo(tx_lo), .rx(rsp_data)
   );

   spi_dm_cs #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) cs_i (
      .clk(clk), .rst_n(rst_n), .load(accept), .sel(req_cs_sel),
      .release_all(done && (chg_q ^ last_q)), .in_gap(state == ST_GAP),
      .pol(cs_pol), .cs_o(cs_o)
   );

   // R5
   high_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> ($stable(mosi) && $stable(mosi2)));
   // R7
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   // R8
   cs_quiet_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sck |-> $stable(cs_o));
   // R11
   ready_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!sck && !mosi && !mosi2));
endmodule

// File: tb/spi_dual_master_tb.sv
module spi_dual_master_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int GAP = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] div_cfg = 8'd2;
   logic [2:0] cs_pol = 3'b010;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [7:0] req_data = 8'h00;
   logic       req_has_data = 1'b0;
   logic       req_dual = 1'b0;
   logic [1:0] req_cs_sel = 2'd0;
   logic       req_cs_change = 1'b0;
   logic       req_last = 1'b0;
   logic       rsp_valid;
   logic [7:0] rsp_data;
   logic       busy, sck, mosi, mosi2;
   logic       miso = 1'b0;
   logic [2:0] cs_o;

   int checks = 0;
   int errors = 0;
   int exp_mask = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_dual_master #(.GAP_CYC(GAP)) dut_i (
      .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .cs_pol(cs_pol),
      .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
      .req_has_data(req_has_data), .req_dual(req_dual), .req_cs_sel(req_cs_sel),
      .req_cs_change(req_cs_change), .req_last(req_last),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy), .sck(sck),
      .mosi(mosi), .mosi2(mosi2), .miso(miso), .cs_o(cs_o)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic [2:0] exp_cs();
      logic [2:0] v;
      for (int i = 0; i < 3; i++) v[i] = exp_mask[i] ? cs_pol[i] : ~cs_pol[i];
      return v;
   endfunction

   // compare all outputs in the current cycle
   task automatic cyc(input string tsck, input string tdat, input string tcs, input string tbsy,
                      input bit e_sck, input bit e_mosi, input bit e_mosi2, input bit e_busy, input bit e_rv);
      chk(tsck, "sck", 32'(sck), 32'(e_sck));
      chk(tdat, "mosi", 32'(mosi), 32'(e_mosi));
      chk(tdat, "mosi2", 32'(mosi2), 32'(e_mosi2));
      chk(tcs, "cs_o", 32'(cs_o), 32'(exp_cs()));
      chk(tbsy, "busy", 32'(busy), 32'(e_busy));
      chk(tbsy, "req_ready", 32'(req_ready), 32'(!e_busy));
      chk("R7", "rsp_valid", 32'(rsp_valid), 32'(e_rv));
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic xfer(input logic [7:0] d, input bit has, input bit dual, input int sel,
                       input bit chg, input bit last, input logic [7:0] slave, input int dv);
      int h = ((dv == 0) ? 1 : dv) + 1;
      int n = dual ? 4 : 8;
      logic [7:0] tx = has ? d : 8'h00;
      logic [7:0] erx = dual ? {4'h0, slave[7:4]} : slave;
      string dtag = !has ? "R6" : (dual ? "R4" : "R3");
      string ftag = (chg && !last) ? "R9" : "R10";
      bit gap = chg && !last;
      bit eh, el;
      div_cfg = 8'(dv);
      req_data = d; req_has_data = has; req_dual = dual; req_cs_sel = 2'(sel);
      req_cs_change = chg; req_last = last; req_valid = 1'b1;
      miso = slave[7];
      chk("R11", "req_ready before accept", 32'(req_ready), 32'd1);
      step();
      req_valid = 1'b0;
      req_data = ~d;
      exp_mask = (sel < 3) ? (1 << sel) : 0;
      for (int c = 0; c < n; c++) begin
         eh = dual ? tx[7-2*c] : tx[7-c];
         el = dual ? tx[6-2*c] : 1'b0;
         for (int j = 0; j < h; j++) begin
            if (j == 0) miso = slave[7-c];
            cyc("R2", dtag, "R8", "R11", 1'b0, eh, el, 1'b1, 1'b0);
            step();
         end
         for (int j = 0; j < h; j++) begin
            cyc("R2", "R5", "R8", "R11", 1'b1, eh, el, 1'b1, 1'b0);
            step();
         end
      end
      if (chg ^ last) exp_mask = 0;
      cyc("R5", "R5", ftag, gap ? "R9" : "R10", 1'b0, 1'b0, 1'b0, gap, 1'b1);
      chk("R7", "rsp_data", 32'(rsp_data), 32'(erx));
      step();
      if (gap) begin
         for (int g = 0; g < GAP - 1; g++) begin
            cyc("R5", "R5", "R9", "R9", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            step();
         end
      end
      cyc("R5", "R5", ftag, "R11", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset state
      cyc("R1", "R1", "R1", "R1", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      step();
      // R3 single, R7 receive, R10 end of message
      xfer(8'hA5, 1, 0, 0, 0, 1, 8'h3C, 2);
      // R4 dual, R2 clamp of zero divider, R8 active-high select
      xfer(8'h5A, 1, 1, 1, 0, 1, 8'h96, 0);
      // R6 zeros, R9 release with gap
      xfer(8'hFF, 0, 0, 2, 1, 0, 8'hFF, 1);
      // R10 mid-message hold, then hold awaiting continuation
      xfer(8'hC3, 1, 0, 0, 0, 0, 8'h81, 3);
      xfer(8'h3C, 1, 1, 0, 1, 1, 8'h0F, 1);
      // R8 switch to another select, then no select
      xfer(8'h81, 1, 0, 1, 0, 1, 8'hE7, 0);
      cs_pol = 3'b101;
      #1;
      xfer(8'h7E, 1, 0, 3, 0, 1, 8'h55, 1);
      xfer(8'h96, 1, 1, 2, 0, 1, 8'hB4, 2);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule